// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast Path

This block gathers up to 32 level-sensitive interrupt requests from peripherals and drives two processor inputs. One is a fast-interrupt line. Every enabled request routed to the fast class is ORed onto it. The other is a normal-interrupt line, fed by the normal class. Normal requests are ranked through 16 vector slots. Each slot binds one source number to a handler address.

Software configures the block over a simple word-addressed register bus. It can read raw and per-class status, and it reads a vector register to fetch the handler address of the winning request. Reading the vector register marks the winner as in service. While an entry is in service, only strictly higher-priority entries may raise the normal line again. A write of any value to the vector register closes the most recent service.

A normal request that no enabled slot claims still raises the normal line. In that case it presents a programmable default address and ranks below every slot.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `fiq_o` equals, one clock later, the OR over all sources of (request AND enable bit AND class bit).
- R2: Reading word address 0x01 returns a word with bit s set exactly when source s is requesting, enabled and in the fast class.
- R3: Enable register (address 0x03, bit s for source s) masks source s from both outputs and from both class status words when its bit is 0.
- R4: Class register (address 0x04): bit s = 1 routes source s to the fast class and bit s = 0 routes it to the normal class; address 0x02 returns the normal-class status word, built the same way as the fast one.
- R5: Address 0x00 returns the request inputs in the same cycle, regardless of enables.
- R6: Slot k has a handler-address register at 0x10+k and a control register at 0x20+k. When several slots are active, reading the vector register (0x05) returns the address of the lowest-indexed active slot.
- R7: Slot control bits [4:0] name the served source and bit 5 enables the slot. A slot with bit 5 clear claims nothing.
- R8: An enabled normal request claimed by no enabled slot raises `irq_o` and ranks below all slots. A vector read then returns the default address register (0x06). A vector read with nothing eligible also returns the default address and changes no state.
- R9: A vector read while `irq_o` is eligible puts the winner in service. If nothing else outranks it, `irq_o` drops on the following clock.
- R10: While entries are in service, only entries ranked strictly above the best in-service entry can raise `irq_o`.
- R11: A write of any value to 0x05 removes the best-ranked in-service entry. The written value is stored nowhere.
- R12: After reset both outputs are 0, all configuration registers read 0 and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Level request per source |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| fiq_o | output | 1 | Fast-interrupt line, registered |
| irq_o | output | 1 | Normal-interrupt line, registered |

## Verification
The hardest state to reach is nested service. A lower-ranked slot is already in service, a higher-ranked one interrupts it, and the end-of-service writes must then unwind the two entries in the correct order while both sources may still be asserting. The bench reaches this state by timing each request change and each vector read against the registered `irq_o`. It checks that a blocked slot stays silent and that the right entry reappears after each acknowledgement. A sweep over every ordered pair of slots then confirms the ranking and the blocking of the loser after the winner is fetched.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int BUS_W   = 32;
  localparam int REG_AW  = 8;
  localparam int SLOT_EN_BIT = 5;

  localparam logic [REG_AW-1:0] A_RAW       = 8'h00;
  localparam logic [REG_AW-1:0] A_FAST_STAT = 8'h01;
  localparam logic [REG_AW-1:0] A_NORM_STAT = 8'h02;
  localparam logic [REG_AW-1:0] A_ENABLE    = 8'h03;
  localparam logic [REG_AW-1:0] A_CLASS     = 8'h04;
  localparam logic [REG_AW-1:0] A_VECTOR    = 8'h05;
  localparam logic [REG_AW-1:0] A_DEFAULT   = 8'h06;
  localparam logic [REG_AW-1:0] A_SLOT_ADDR = 8'h10;
  localparam logic [REG_AW-1:0] A_SLOT_CTRL = 8'h20;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [REG_AW-1:0]   addr,
  input  logic [BUS_W-1:0]    wdata,
  output logic [NUM_SRC-1:0]  src_en_o,
  output logic [NUM_SRC-1:0]  src_fast_o,
  output logic [BUS_W-1:0]    dflt_addr_o,
  output logic [BUS_W-1:0]    slot_addr_o [NUM_SLOT],
  output logic [SRC_W-1:0]    slot_src_o  [NUM_SLOT],
  output logic [NUM_SLOT-1:0] slot_en_o
);
  logic [NUM_SRC-1:0]  en_q,   en_d;
  logic [NUM_SRC-1:0]  fast_q, fast_d;
  logic [BUS_W-1:0]    dflt_q, dflt_d;
  logic [BUS_W-1:0]    saddr_q [NUM_SLOT];
  logic [BUS_W-1:0]    saddr_d [NUM_SLOT];
  logic [SRC_W-1:0]    ssrc_q  [NUM_SLOT];
  logic [SRC_W-1:0]    ssrc_d  [NUM_SLOT];
  logic [NUM_SLOT-1:0] sen_q,  sen_d;

  // next-state: decode one write per cycle
  always_comb begin
    en_d    = en_q;
    fast_d  = fast_q;
    dflt_d  = dflt_q;
    saddr_d = saddr_q;
    ssrc_d  = ssrc_q;
    sen_d   = sen_q;
    if (wr_stb) begin
      case (addr)
        A_ENABLE:  en_d   = wdata[NUM_SRC-1:0];
        A_CLASS:   fast_d = wdata[NUM_SRC-1:0];
        A_DEFAULT: dflt_d = wdata;
        default: ;
      endcase
      for (int k = 0; k < NUM_SLOT; k++) begin
        if (addr == A_SLOT_ADDR + REG_AW'(k)) saddr_d[k] = wdata;
        if (addr == A_SLOT_CTRL + REG_AW'(k)) begin
          ssrc_d[k] = wdata[SRC_W-1:0];
          sen_d[k]  = wdata[SLOT_EN_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      fast_q <= '0;
      dflt_q <= '0;
      sen_q  <= '0;
      for (int k = 0; k < NUM_SLOT; k++) begin
        saddr_q[k] <= '0;
        ssrc_q[k]  <= '0;
      end
    end else if (wr_stb) begin
      en_q    <= en_d;
      fast_q  <= fast_d;
      dflt_q  <= dflt_d;
      saddr_q <= saddr_d;
      ssrc_q  <= ssrc_d;
      sen_q   <= sen_d;
    end
  end

  assign src_en_o    = en_q;
  assign src_fast_o  = fast_q;
  assign dflt_addr_o = dflt_q;
  assign slot_addr_o = saddr_q;
  assign slot_src_o  = ssrc_q;
  assign slot_en_o   = sen_q;
endmodule

// File: rtl/ivc_arb.sv
module ivc_arb
  import ivc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int SRC_W    = $clog2(NUM_SRC),
  parameter int WIN_W    = $clog2(NUM_SLOT + 2)
) (
  input  logic [NUM_SRC-1:0]  norm_req,
  input  logic [BUS_W-1:0]    slot_addr [NUM_SLOT],
  input  logic [SRC_W-1:0]    slot_src  [NUM_SLOT],
  input  logic [NUM_SLOT-1:0] slot_en,
  input  logic [BUS_W-1:0]    dflt_addr,
  input  logic [NUM_SLOT:0]   in_svc,
  output logic                grant_valid,
  output logic [WIN_W-1:0]    grant_idx,
  output logic [BUS_W-1:0]    vec_addr
);
  // entry NUM_SLOT stands for the unclaimed (default) request
  logic [NUM_SLOT:0]  cand;
  logic [NUM_SRC-1:0] claimed;
  logic [WIN_W-1:0]   win, ceil_idx;
  logic [BUS_W-1:0]   win_addr;

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_hit
    assign cand[k] = slot_en[k] & norm_req[slot_src[k]];
  end

  always_comb begin
    claimed = '0;
    for (int k = 0; k < NUM_SLOT; k++)
      if (slot_en[k]) claimed[slot_src[k]] = 1'b1;
  end
  assign cand[NUM_SLOT] = |(norm_req & ~claimed);

  // lowest index wins
  always_comb begin
    win = WIN_W'(NUM_SLOT);
    for (int i = NUM_SLOT; i >= 0; i--)
      if (cand[i]) win = WIN_W'(i);
  end

  // best in-service entry sets the ceiling
  always_comb begin
    ceil_idx = WIN_W'(NUM_SLOT + 1);
    for (int i = NUM_SLOT; i >= 0; i--)
      if (in_svc[i]) ceil_idx = WIN_W'(i);
  end

  always_comb begin
    win_addr = dflt_addr;
    for (int k = 0; k < NUM_SLOT; k++)
      if (win == WIN_W'(k)) win_addr = slot_addr[k];
  end

  assign grant_valid = (|cand) && (win < ceil_idx);
  assign grant_idx   = win;
  assign vec_addr    = grant_valid ? win_addr : dflt_addr;
endmodule

// File: rtl/ivc_svc.sv
module ivc_svc #(
  parameter int NUM_SLOT = 16,
  parameter int WIN_W    = $clog2(NUM_SLOT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic [WIN_W-1:0]  ack_idx,
  input  logic              eos,
  output logic [NUM_SLOT:0] in_svc
);
  logic [NUM_SLOT:0] svc_q, svc_d;
  logic              svc_ce;

  assign svc_ce = ack | eos;

  always_comb begin
    svc_d = svc_q;
    if (ack) begin
      for (int i = 0; i <= NUM_SLOT; i++)
        if (ack_idx == WIN_W'(i)) svc_d[i] = 1'b1;
    end else if (eos) begin
      svc_d = svc_q & (svc_q - 1'b1);  // drop lowest set bit
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svc_q <= '0;
    else if (svc_ce) svc_q <= svc_d;
  end

  assign in_svc = svc_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               fiq_o,
  output logic               irq_o
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int WIN_W = $clog2(NUM_SLOT + 2);

  logic [NUM_SRC-1:0]  src_en, src_fast, fast_masked, norm_masked;
  logic [BUS_W-1:0]    dflt_addr, vec_addr;
  logic [BUS_W-1:0]    slot_addr [NUM_SLOT];
  logic [SRC_W-1:0]    slot_src  [NUM_SLOT];
  logic [NUM_SLOT-1:0] slot_en;
  logic [NUM_SLOT:0]   in_svc;
  logic                grant_valid, ack, eos, wr_stb, vec_rd;
  logic [WIN_W-1:0]    grant_idx;
  logic                fiq_q, fiq_d, irq_q, irq_d;

  assign wr_stb = bus_sel & bus_wr;
  assign vec_rd = bus_sel & ~bus_wr & (bus_addr == A_VECTOR);
  assign eos    = wr_stb & (bus_addr == A_VECTOR);
  assign ack    = vec_rd & grant_valid;

  assign fast_masked = irq_src_i & src_en & src_fast;
  assign norm_masked = irq_src_i & src_en & ~src_fast;

  ivc_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(bus_addr), .wdata(bus_wdata),
    .src_en_o(src_en), .src_fast_o(src_fast), .dflt_addr_o(dflt_addr),
    .slot_addr_o(slot_addr), .slot_src_o(slot_src), .slot_en_o(slot_en)
  );

  ivc_arb #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .SRC_W(SRC_W), .WIN_W(WIN_W)) u_arb (
    .norm_req(norm_masked), .slot_addr(slot_addr), .slot_src(slot_src),
    .slot_en(slot_en), .dflt_addr(dflt_addr), .in_svc(in_svc),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .vec_addr(vec_addr)
  );

  ivc_svc #(.NUM_SLOT(NUM_SLOT), .WIN_W(WIN_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .ack(ack), .ack_idx(grant_idx), .eos(eos), .in_svc(in_svc)
  );

  // output line registers
  assign fiq_d = |fast_masked;
  assign irq_d = grant_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      fiq_q <= fiq_d;
      irq_q <= irq_d;
    end
  end

  assign fiq_o = fiq_q;
  assign irq_o = irq_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RAW:       bus_rdata[NUM_SRC-1:0] = irq_src_i;
      A_FAST_STAT: bus_rdata[NUM_SRC-1:0] = fast_masked;
      A_NORM_STAT: bus_rdata[NUM_SRC-1:0] = norm_masked;
      A_ENABLE:    bus_rdata[NUM_SRC-1:0] = src_en;
      A_CLASS:     bus_rdata[NUM_SRC-1:0] = src_fast;
      A_VECTOR:    bus_rdata = vec_addr;
      A_DEFAULT:   bus_rdata = dflt_addr;
      default: ;
    endcase
    for (int k = 0; k < NUM_SLOT; k++) begin
      if (bus_addr == A_SLOT_ADDR + REG_AW'(k)) bus_rdata = slot_addr[k];
      if (bus_addr == A_SLOT_CTRL + REG_AW'(k)) begin
        bus_rdata[SRC_W-1:0]   = slot_src[k];
        bus_rdata[SLOT_EN_BIT] = slot_en[k];
      end
    end
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int WIN_W    = $clog2(NUM_SLOT + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] fast_masked,
  input logic [NUM_SLOT:0]  in_svc,
  input logic               ack,
  input logic               eos,
  input logic               grant_valid,
  input logic [WIN_W-1:0]   grant_idx
);
  logic [NUM_SLOT:0] at_or_below;

  always_comb begin
    for (int i = 0; i <= NUM_SLOT; i++)
      at_or_below[i] = (WIN_W'(i) <= grant_idx);
  end

  // R1: fast line is the registered OR of masked fast requests
  a_r1_fast_or: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fiq_o == $past(|fast_masked)));

  // R9: an acknowledged fetch adds exactly one in-service entry
  a_r9_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ($countones(in_svc) == $past($countones(in_svc)) + 1));

  // R11: end of service removes exactly one entry when any exists
  a_r11_eos_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && (|in_svc)) |=> ($countones(in_svc) == $past($countones(in_svc)) - 1));

  // R11: end of service with nothing in service leaves it empty
  a_r11_eos_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !(|in_svc)) |=> (in_svc == '0));

  // R10: an eligible winner always ranks above every in-service entry
  a_r10_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((in_svc & at_or_below) == '0));
endmodule

bind irq_vector_ctrl ivc_checker #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fiq_o(fiq_o), .fast_masked(fast_masked),
  .in_svc(in_svc), .ack(ack), .eos(eos),
  .grant_valid(grant_valid), .grant_idx(grant_idx)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  import ivc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_src;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fiq_o, irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [31:0] DFLT = 32'hDEAD_0000;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] slot_vec(int k);
    return 32'h4000_0000 + 32'(k) * 32'h100;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; irq_src = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R12 reset state
    chk("R12 fiq", {31'b0, fiq_o}, 0);
    chk("R12 irq", {31'b0, irq_o}, 0);
    rd(A_ENABLE, d);  chk("R12 enable", d, 0);
    rd(A_CLASS, d);   chk("R12 class", d, 0);
    rd(A_VECTOR, d);  chk("R12 vector", d, 0);
    rd(A_SLOT_CTRL + 8'd7, d); chk("R12 slot ctrl", d, 0);

    // R5 raw view, R3 masked while enables are clear
    for (int s = 0; s < 32; s++) begin
      irq_src = 32'h1 << s;
      rd(A_RAW, d); chk("R5 raw walk", d, 32'h1 << s);
    end
    irq_src = 32'hA5C3_0F81;
    rd(A_RAW, d); chk("R5 raw pattern", d, 32'hA5C3_0F81);
    settle();
    chk("R3 fiq masked", {31'b0, fiq_o}, 0);
    chk("R3 irq masked", {31'b0, irq_o}, 0);
    irq_src = '0;

    // R1/R2 fast path sweep
    wr(A_ENABLE, 32'hFFFF_FFFF);
    wr(A_CLASS, 32'hFFFF_FFFF);
    wr(A_DEFAULT, DFLT);
    for (int s = 0; s < 32; s++) begin
      irq_src = 32'h1 << s;
      settle();
      chk("R1 fiq on", {31'b0, fiq_o}, 1);
      chk("R4 fast class keeps irq low", {31'b0, irq_o}, 0);
      rd(A_FAST_STAT, d); chk("R2 fast status", d, 32'h1 << s);
      irq_src = '0;
      settle();
      chk("R1 fiq off", {31'b0, fiq_o}, 0);
    end
    irq_src = 32'h8000_0011;
    rd(A_FAST_STAT, d); chk("R2 fast status multi", d, 32'h8000_0011);
    settle(); chk("R1 fiq multi", {31'b0, fiq_o}, 1);
    irq_src = '0;

    // R3 per-source masking
    for (int s = 0; s < 32; s++) begin
      wr(A_ENABLE, ~(32'h1 << s));
      irq_src = 32'h1 << s;
      settle();
      chk("R3 fiq masked", {31'b0, fiq_o}, 0);
      rd(A_FAST_STAT, d); chk("R3 fast status masked", d, 0);
      irq_src = '0;
    end
    wr(A_ENABLE, 32'hFFFF_FFFF);

    // R4 normal class, R8 default address with no slots enabled
    wr(A_CLASS, 32'h0);
    for (int s = 0; s < 32; s += 5) begin
      irq_src = 32'h1 << s;
      settle();
      chk("R4 normal irq", {31'b0, irq_o}, 1);
      chk("R4 normal no fiq", {31'b0, fiq_o}, 0);
      rd(A_NORM_STAT, d); chk("R4 normal status", d, 32'h1 << s);
      rd(A_VECTOR, d); chk("R8 default vector", d, DFLT);
      settle();
      chk("R9 irq drops after fetch", {31'b0, irq_o}, 0);
      irq_src = '0;
      wr(A_VECTOR, 32'h0);
    end

    // slot setup: slot k serves source 2k
    for (int k = 0; k < 16; k++) begin
      wr(A_SLOT_ADDR + 8'(k), slot_vec(k));
      wr(A_SLOT_CTRL + 8'(k), 32'h20 | 32'(2 * k));
    end
    rd(A_SLOT_CTRL + 8'd9, d); chk("R7 ctrl readback", d, 32'h32);

    // R6/R10 every ordered pair of slots
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        irq_src = (32'h1 << (2 * a)) | (32'h1 << (2 * b));
        settle();
        chk("R6 irq pair", {31'b0, irq_o}, 1);
        rd(A_VECTOR, d); chk("R6 pair winner", d, slot_vec(a < b ? a : b));
        settle();
        chk("R10 loser blocked", {31'b0, irq_o}, 0);
        irq_src = '0;
        wr(A_VECTOR, 32'(a * 16 + b));
      end
    end

    // R7 disabled slot claims nothing
    wr(A_SLOT_CTRL + 8'd3, 32'h06);
    irq_src = 32'h1 << 6;
    settle();
    chk("R7 unclaimed irq", {31'b0, irq_o}, 1);
    rd(A_VECTOR, d); chk("R7 disabled slot gives default", d, DFLT);
    irq_src = '0;
    wr(A_VECTOR, 32'h0);
    wr(A_SLOT_CTRL + 8'd3, 32'h26);

    // R8 slot beats unclaimed request
    irq_src = (32'h1 << 1) | (32'h1 << 30);
    settle();
    rd(A_VECTOR, d); chk("R8 slot above default", d, slot_vec(15));
    irq_src = '0;
    wr(A_VECTOR, 32'h0);

    // R10/R11 nesting
    irq_src = 32'h1 << 10;                 // slot 5
    settle();
    rd(A_VECTOR, d); chk("R10 fetch slot5", d, slot_vec(5));
    irq_src = irq_src | (32'h1 << 16);     // slot 8
    settle(); settle();
    chk("R10 slot8 blocked", {31'b0, irq_o}, 0);
    irq_src = irq_src | (32'h1 << 4);      // slot 2
    settle();
    chk("R10 slot2 preempts", {31'b0, irq_o}, 1);
    rd(A_VECTOR, d); chk("R10 fetch slot2", d, slot_vec(2));
    settle();
    chk("R9 irq drops nested", {31'b0, irq_o}, 0);
    wr(A_VECTOR, 32'hFFFF_FFFF);           // pops slot 2
    settle();
    chk("R11 slot2 eligible again", {31'b0, irq_o}, 1);
    irq_src = irq_src & ~(32'h1 << 4);
    settle(); settle();
    chk("R11 slot5 still in service", {31'b0, irq_o}, 0);
    rd(A_VECTOR, d); chk("R8 idle vector read", d, DFLT);
    rd(A_SLOT_ADDR + 8'd2, d); chk("R11 written value not stored", d, slot_vec(2));
    rd(A_DEFAULT, d); chk("R11 default untouched", d, DFLT);
    wr(A_VECTOR, 32'h1234_5678);           // pops slot 5
    settle();
    chk("R11 slot5 eligible", {31'b0, irq_o}, 1);
    irq_src = 32'h1 << 16;
    settle();
    rd(A_VECTOR, d); chk("R11 slot8 now wins", d, slot_vec(8));
    irq_src = '0;
    wr(A_VECTOR, 32'h0);
    settle();
    chk("R11 all clear", {31'b0, irq_o}, 0);

    finish_run();
  end
endmodule